// File: doc/BRIEF.md
# Pause Frame Transmit Sequencer

This block sends one MAC-control pause frame each time software asks for one while the link runs full duplex. A one-cycle set pulse raises an internal request bit and, with it, a graceful-stop signal. That signal tells the data transmitter to finish its current frame and stop taking new ones. The sequencer then waits for the transmitter to report that it is idle. When it is, the sequencer raises a one-cycle stop-complete interrupt and streams the pause frame as bytes on a valid/ready port.

The frame is built from fixed protocol constants and from two configuration inputs: the station's 48-bit address and a 16-bit pause duration. Both are captured when the request is accepted. The frame carries no preamble and no FCS; a downstream MAC stage adds those. After the 18 header and duration bytes, zero padding brings the frame to 60 bytes. The last byte is flagged. Once the last byte has been accepted, hardware clears both the request bit and the graceful stop, so normal traffic can resume.

Top module: `pause_tx_seq`

## Requirements
- R1: A set pulse while `fdx_en` is low is ignored: `pause_req`, `gts`, `stop_done` and `out_valid` all stay low.
- R2: A set pulse with `fdx_en` high, sampled at a clock edge while idle, makes `pause_req` and `gts` high from that edge on.
- R3: While `tx_idle` is low after a request, `stop_done` and `out_valid` stay low. `stop_done` is high for exactly the one cycle that follows the first edge at which `tx_idle` is sampled high.
- R4: `out_valid` rises in the cycle after the `stop_done` cycle, carrying byte 0, and never earlier.
- R5: Bytes 0 to 5 are 01, 80, C2, 00, 00, 01.
- R6: Bytes 6 to 11 are the station address, most significant byte first, as it stood when the request was accepted. Later changes to `station_addr` have no effect on the frame in progress.
- R7: Bytes 12 to 15 are 88, 08, 00, 01.
- R8: Bytes 16 and 17 are `pause_quanta`, most significant byte first, as captured with the request.
- R9: Bytes 18 to 59 are zero. `out_last` is high on byte 59 only, so the frame is exactly 60 bytes.
- R10: A byte is consumed only at an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold.
- R11: In the cycle after the last byte is accepted, `pause_req`, `gts` and `out_valid` are low.
- R12: Set pulses that arrive while a request is in progress are ignored: exactly one frame is sent, and no new request follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fdx_en | input | 1 | Link is in full-duplex mode |
| pause_req_set | input | 1 | One-cycle software request to send a pause frame |
| tx_idle | input | 1 | Data transmitter has stopped and is idle |
| station_addr | input | 48 | Station address placed in the source field |
| pause_quanta | input | 16 | Programmed pause duration |
| out_ready | input | 1 | Downstream accepts the current byte |
| pause_req | output | 1 | Request bit, cleared by hardware at frame end |
| gts | output | 1 | Graceful transmit stop to the data transmitter |
| stop_done | output | 1 | One-cycle stop-complete interrupt |
| out_data | output | 8 | Frame byte |
| out_valid | output | 1 | `out_data` holds a frame byte |
| out_last | output | 1 | Current byte is the last of the frame |

## Verification
`pause_req` and `gts` are due one cycle after the accepted set pulse. `stop_done` is due one cycle after the edge that samples `tx_idle` high, and the first byte one cycle after that. Each byte advances one cycle after a handshake edge, and the clears are due one cycle after the last handshake. The bench drives inputs on the falling edge and reads outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Random ready gaps, random stop-wait lengths, and address changes made in the middle of a frame are compared against a byte function in the bench. Directed cases cover the half-duplex request, a zero-length wait and durations of 0000 and FFFF.

// File: rtl/pause_pkg.sv
package pause_pkg;

  localparam int HDR_BYTES = 18;
  localparam int HDR_BITS  = HDR_BYTES * 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STOP,
    ST_DONE,
    ST_SEND
  } pause_st_e;

  // Picks byte idx of the header (MSB first); bytes past the header are zero.
  function automatic logic [7:0] hdr_byte(input logic [HDR_BITS-1:0] hdr,
                                          input int unsigned idx);
    logic [HDR_BITS-1:0] sh;
    if (idx >= HDR_BYTES) return 8'h00;
    sh = hdr << (8 * idx);
    return sh[HDR_BITS-1 -: 8];
  endfunction

endpackage

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fdx_en,
  input  logic req_set,
  input  logic tx_idle,
  input  logic frame_end,
  output logic pause_req,
  output logic gts,
  output logic stop_done,
  output logic cap_en,
  output logic start
);

  pause_st_e st;

  assign cap_en = (st == ST_IDLE) && req_set && fdx_en;
  assign start  = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pause_req <= 1'b0;
      gts       <= 1'b0;
      stop_done <= 1'b0;
    end else begin
      stop_done <= 1'b0;
      case (st)
        ST_IDLE: if (req_set && fdx_en) begin
          pause_req <= 1'b1;
          gts       <= 1'b1;
          st        <= ST_STOP;
        end
        ST_STOP: if (tx_idle) begin
          stop_done <= 1'b1;
          st        <= ST_DONE;
        end
        ST_DONE: st <= ST_SEND;
        ST_SEND: if (frame_end) begin
          pause_req <= 1'b0;
          gts       <= 1'b0;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pause_cfg_latch.sv
module pause_cfg_latch #(
  parameter int ADDR_W = 48,
  parameter int DUR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DUR_W-1:0]  dur_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DUR_W-1:0]  dur_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dur_q  <= '0;
    end else if (cap_en) begin
      addr_q <= addr_in;
      dur_q  <= dur_in;
    end
  end

endmodule

// File: rtl/pause_byte_gen.sv
module pause_byte_gen
  import pause_pkg::*;
#(
  parameter int          FRAME_LEN = 60,
  parameter logic [47:0] DST_ADDR  = 48'h0180_C200_0001,
  parameter logic [15:0] ETYPE     = 16'h8808,
  parameter logic [15:0] OPCODE    = 16'h0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [47:0] src_addr,
  input  logic [15:0] quanta,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  output logic        frame_end
);

  localparam int IDX_W = $clog2(FRAME_LEN + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [HDR_BITS-1:0] hdr;
  logic [IDX_W-1:0]    idx;
  logic                take;

  assign hdr       = {DST_ADDR, src_addr, ETYPE, OPCODE, quanta};
  assign take      = out_valid && out_ready;
  assign frame_end = take && out_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else if (start) begin
      out_data  <= hdr_byte(hdr, 0);
      out_valid <= 1'b1;
      out_last  <= (FRAME_LEN == 1);
      idx       <= IDX_W'(1);
    end else if (take) begin
      if (out_last) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
        out_data  <= '0;
        idx       <= '0;
      end else begin
        out_data <= hdr_byte(hdr, 32'(idx));
        out_last <= (idx == LAST_IDX);
        idx      <= idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/pause_tx_seq.sv
module pause_tx_seq #(
  parameter int          FRAME_LEN = 60,
  parameter logic [47:0] DST_ADDR  = 48'h0180_C200_0001,
  parameter logic [15:0] ETYPE     = 16'h8808,
  parameter logic [15:0] OPCODE    = 16'h0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fdx_en,
  input  logic        pause_req_set,
  input  logic        tx_idle,
  input  logic [47:0] station_addr,
  input  logic [15:0] pause_quanta,
  input  logic        out_ready,
  output logic        pause_req,
  output logic        gts,
  output logic        stop_done,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last
);

  logic        cap_en, start, frame_end;
  logic [47:0] sa_q;
  logic [15:0] dur_q;

  pause_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fdx_en    (fdx_en),
    .req_set   (pause_req_set),
    .tx_idle   (tx_idle),
    .frame_end (frame_end),
    .pause_req (pause_req),
    .gts       (gts),
    .stop_done (stop_done),
    .cap_en    (cap_en),
    .start     (start)
  );

  pause_cfg_latch #(.ADDR_W(48), .DUR_W(16)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (cap_en),
    .addr_in (station_addr),
    .dur_in  (pause_quanta),
    .addr_q  (sa_q),
    .dur_q   (dur_q)
  );

  pause_byte_gen #(
    .FRAME_LEN (FRAME_LEN),
    .DST_ADDR  (DST_ADDR),
    .ETYPE     (ETYPE),
    .OPCODE    (OPCODE)
  ) u_gen (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .src_addr  (sa_q),
    .quanta    (dur_q),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .frame_end (frame_end)
  );

endmodule

// File: rtl/pause_tx_seq_chk.sv
module pause_tx_seq_chk #(
  parameter int FRAME_LEN = 60
) (
  input logic       clk,
  input logic       rst,
  input logic       fdx_en,
  input logic       tx_idle,
  input logic       out_ready,
  input logic       pause_req,
  input logic       gts,
  input logic       stop_done,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_last
);

  logic [15:0] beat_cnt;

  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (out_valid && out_ready) beat_cnt <= out_last ? '0 : beat_cnt + 16'd1;
  end

  AST_HALF_DUPLEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!pause_req && !fdx_en) |=> !pause_req); // R1

  AST_VALID_UNDER_STOP: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gts && pause_req)); // R2

  AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_done) |-> $past(tx_idle)); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stop_done |=> !stop_done); // R3

  AST_FIRST_BYTE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    stop_done |=> out_valid); // R4

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (beat_cnt == 16'(FRAME_LEN - 1))); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (!pause_req && !gts && !out_valid)); // R11

endmodule

bind pause_tx_seq pause_tx_seq_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fdx_en    (fdx_en),
  .tx_idle   (tx_idle),
  .out_ready (out_ready),
  .pause_req (pause_req),
  .gts       (gts),
  .stop_done (stop_done),
  .out_data  (out_data),
  .out_valid (out_valid),
  .out_last  (out_last)
);

// File: tb/pause_tx_seq_bench.sv
module pause_tx_seq_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        fdx_en, pause_req_set, tx_idle, out_ready;
  logic [47:0] station_addr;
  logic [15:0] pause_quanta;
  logic        pause_req, gts, stop_done, out_valid, out_last;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pause_tx_seq u_pause_tx_seq (
    .clk (clk), .rst (rst), .fdx_en (fdx_en), .pause_req_set (pause_req_set),
    .tx_idle (tx_idle), .station_addr (station_addr), .pause_quanta (pause_quanta),
    .out_ready (out_ready), .pause_req (pause_req), .gts (gts), .stop_done (stop_done),
    .out_data (out_data), .out_valid (out_valid), .out_last (out_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int n, input logic [47:0] sa, input logic [15:0] q);
    logic [143:0] h = {48'h0180C2000001, sa, 16'h8808, 16'h0001, q};
    if (n >= 18) return 8'h00;
    return h[143 - 8*n -: 8];
  endfunction

  function automatic string byte_tag(input int n);
    if (n < 6)  return "R5 dst byte";
    if (n < 12) return "R6 src byte";
    if (n < 16) return "R7 type/opcode byte";
    if (n < 18) return "R8 duration byte";
    return "R9 pad byte";
  endfunction

  task automatic run_frame(input int delay, input bit all_ready,
                           input logic [47:0] sa, input logic [15:0] q);
    int got = 0;
    bit hold = 0;
    logic [7:0] hold_data = '0;
    int guard = 0;
    @(negedge clk);
    fdx_en = 1; station_addr = sa; pause_quanta = q; tx_idle = 0; pause_req_set = 1;
    @(negedge clk);
    pause_req_set = 0;
    chk(pause_req == 1, "R2 pause_req", 64'(pause_req), 1);
    chk(gts == 1, "R2 gts", 64'(gts), 1);
    for (int i = 0; i < delay; i++) begin
      chk(!stop_done && !out_valid, "R3 early stop/valid", {stop_done, out_valid}, 0);
      pause_req_set = 1'($urandom % 2);          // R12 pulses while busy
      station_addr  = {$urandom, $urandom};      // R6 change after capture
      pause_quanta  = 16'($urandom);
      @(negedge clk);
      pause_req_set = 0;
    end
    chk(!stop_done, "R3 stop_done before idle", 64'(stop_done), 0);
    tx_idle = 1;
    @(negedge clk);
    chk(stop_done == 1, "R3 stop_done pulse", 64'(stop_done), 1);
    chk(!out_valid, "R4 valid with stop_done", 64'(out_valid), 0);
    tx_idle = 1'($urandom % 2);
    while (got < 60 && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (got == 0 && guard == 1) begin
        chk(stop_done == 0, "R3 stop_done width", 64'(stop_done), 0);
        chk(out_valid == 1, "R4 first byte valid", 64'(out_valid), 1);
      end
      if (hold) begin
        chk(out_valid && out_data == hold_data, "R10 hold on stall", {out_valid, out_data}, {1'b1, hold_data});
      end
      out_ready = all_ready ? 1'b1 : 1'($urandom % 3 != 0);
      pause_req_set = 1'($urandom % 8 == 0);     // R12
      station_addr  = {$urandom, $urandom};      // R6
      if (out_valid && out_ready) begin
        chk(out_data == exp_byte(got, sa, q), byte_tag(got), 64'(out_data), 64'(exp_byte(got, sa, q)));
        chk(out_last == (got == 59), "R9 last flag", 64'(out_last), 64'(got == 59));
        got++;
        hold = 0;
      end else begin
        hold = out_valid;
        hold_data = out_data;
      end
    end
    chk(got == 60, "R9 byte count", 64'(got), 60);
    @(negedge clk);
    out_ready = 0; pause_req_set = 0;
    chk(!pause_req && !gts && !out_valid, "R11 clears", {pause_req, gts, out_valid}, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!pause_req && !out_valid && !stop_done, "R12 no second frame",
          {pause_req, out_valid, stop_done}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL WATCHDOG actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; fdx_en = 0; pause_req_set = 0; tx_idle = 0; out_ready = 0;
    station_addr = '0; pause_quanta = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!pause_req && !gts && !stop_done && !out_valid && !out_last, "reset state",
        {pause_req, gts, stop_done, out_valid, out_last}, 0);

    // R1: half duplex request ignored
    tx_idle = 1; out_ready = 1; fdx_en = 0; pause_req_set = 1;
    @(negedge clk);
    pause_req_set = 0;
    repeat (4) begin
      chk(!pause_req && !gts && !stop_done && !out_valid, "R1 half duplex ignored",
          {pause_req, gts, stop_done, out_valid}, 0);
      @(negedge clk);
    end

    run_frame(0, 1'b1, 48'h0011_2233_4455, 16'h0000);
    run_frame(2, 1'b0, 48'hFFFF_FFFF_FFFF, 16'hFFFF);
    for (int k = 0; k < 6; k++) begin
      run_frame(int'($urandom % 6), 1'b0, {$urandom, $urandom}, 16'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule